// File: doc/BRIEF.md
# Early-Forward Load Fast Path

This block sits beside a small direct-mapped level-one data cache in an in-order pipeline. A load request enters in EX1. The tag, valid bit and data word of the addressed line are read from block-RAM-style arrays on that clock edge, and the load is evaluated in EX2. The normal path delivers a registered result in EX3, three cycles after the request. The fast path covers only aligned 32-bit and 64-bit loads to ordinary RAM that hit in the cache and overlap no pending store. For those loads the fast path raises a registered early flag with the data one cycle sooner, so EX2 forwarding can use the value.

The normal path is a separate general byte aligner. It handles every size and offset within an 8-byte line. It raises a replay flag for a miss, an uncached (MMIO) access, a store-buffer overlap, or an access that crosses the line boundary. The fast path is a narrow word/doubleword selector of its own. Whenever the early flag is set, both paths must deliver the same value.

Lines are installed and invalidated through a simple fill port. A four-entry pending-store buffer holds the addresses of stores not yet written to the cache. It accepts pushes and drains oldest-first.

Top module: `lfp_load_fastpath`

## Requirements
- R1: An aligned load of size code 3 (64-bit) or 2 (32-bit) that is not uncached, hits a valid line with a matching tag, and overlaps no pending store raises early_valid with the loaded value two clock edges after the request edge. ex3_valid follows one edge later with ex3_replay low.
- R2: Loads with size code 0 (8-bit) or 1 (16-bit) never raise early_valid. Their data appears only on ex3_data, three edges after the request.
- R3: A load whose address is not a multiple of its size never raises early_valid.
- R4: A load with req_mmio high never raises early_valid, and its EX3 result carries ex3_replay high.
- R5: A load whose 8-byte-aligned address equals that of any valid store-buffer entry never raises early_valid, and raises ex3_replay. Once that entry drains, the same load takes the fast path again.
- R6: A load to a line that is invalid, or that holds a different tag, never raises early_valid, and raises ex3_replay.
- R7: Whenever early_valid is high, the next cycle has ex3_valid high, ex3_replay low and ex3_data equal to the early data.
- R8: A 32-bit load is sign-extended to 64 bits when req_signed is 1 and zero-extended when it is 0, on both paths. Memory is little-endian, with byte k of a line at data bits 8k+7..8k.
- R9: The normal path returns correct data for misaligned loads that stay inside one 8-byte line. It raises ex3_replay for a load whose bytes cross the line boundary.
- R10: After reset, early_valid, ex3_valid and st_full are low, and the store buffer is empty.
- R11: While the store buffer holds four entries, st_full is high and a push is ignored. A load to the ignored store's address then still takes the fast path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request in EX1 |
| req_addr | input | 32 | Load byte address |
| req_size | input | 2 | 0=8-bit, 1=16-bit, 2=32-bit, 3=64-bit |
| req_signed | input | 1 | Sign-extend the loaded value |
| req_mmio | input | 1 | Access targets uncached/non-RAM space |
| fill_we | input | 1 | Install a line (tag, data, valid) |
| fill_inv | input | 1 | Invalidate the line at fill_addr |
| fill_addr | input | 32 | Line address for fill/invalidate |
| fill_data | input | 64 | Line data for fill |
| st_push | input | 1 | Add a pending store address |
| st_addr | input | 32 | Pending store address |
| st_drain | input | 1 | Retire the oldest pending store |
| st_full | output | 1 | Store buffer holds four entries |
| early_valid | output | 1 | Early result valid (EX2 forwarding) |
| early_data | output | 64 | Early load result |
| ex3_valid | output | 1 | Normal-path result valid |
| ex3_data | output | 64 | Normal-path load result |
| ex3_replay | output | 1 | Load needs service outside the cache hit path |

## Verification
The bench targets the gates of the qualifying condition one at a time. It issues loads that are correct in every respect but one: a narrow size, a two-byte offset, the uncached attribute, a tag mismatch, or a store that touches only the other half of the same 8-byte line. A design that dropped any one of these gates would raise the early flag and forward a value that the normal path later replays or returns differently. The bench checks sign and zero extension of both halves of a line, because a selector with a wrong half or wrong extension would produce early data different from the EX3 value. It also covers a load that crosses the line boundary and a push into a full store buffer, where a buffer that overwrote an entry would lose a real hazard.

// File: rtl/lfp_pkg.sv
package lfp_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } lfp_size_e;

  localparam int unsigned LINE_BYTES = 8;
  localparam int unsigned LINE_OFF_W = 3;
  localparam int unsigned WORD_BITS  = 64;
endpackage

// File: rtl/lfp_cache_arrays.sv
module lfp_cache_arrays #(
  parameter int unsigned INDEX_W = 4,
  parameter int unsigned TAG_W   = 25,
  parameter int unsigned DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] rd_index,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               wr_en,
  input  logic               wr_inv,
  input  logic [INDEX_W-1:0] wr_index,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [DATA_W-1:0]  wr_data
);
  localparam int unsigned SETS = 1 << INDEX_W;

  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [SETS];
  logic [SETS-1:0]   line_ok;

  // Tag and data: plain synchronous RAMs, read-first, no reset.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_index]  <= wr_tag;
      data_mem[wr_index] <= wr_data;
    end
    rd_tag  <= tag_mem[rd_index];
    rd_data <= data_mem[rd_index];
  end

  // Valid bits live in flops so reset can clear them.
  always_ff @(posedge clk) begin
    if (rst) begin
      line_ok  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= line_ok[rd_index];
      if (wr_inv)     line_ok[wr_index] <= 1'b0;
      else if (wr_en) line_ok[wr_index] <= 1'b1;
    end
  end
endmodule

// File: rtl/lfp_store_buf.sv
module lfp_store_buf #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned KEY_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [KEY_W-1:0] push_key,
  input  logic             pop,
  input  logic [KEY_W-1:0] probe_key,
  output logic             probe_hit,
  output logic             full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [KEY_W-1:0] key_q [DEPTH];
  logic [DEPTH-1:0] busy_q;
  logic [PTR_W-1:0] head_q, tail_q;
  logic [DEPTH-1:0] match;
  logic             do_push, do_pop;

  assign full    = busy_q[tail_q];
  assign do_push = push && !full;
  assign do_pop  = pop && busy_q[head_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (do_pop) begin
        busy_q[head_q] <= 1'b0;
        head_q         <= (head_q == LAST) ? '0 : head_q + 1'b1;
      end
      if (do_push) begin
        busy_q[tail_q] <= 1'b1;
        tail_q         <= (tail_q == LAST) ? '0 : tail_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) key_q[tail_q] <= push_key;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_probe
    assign match[g] = busy_q[g] && (key_q[g] == probe_key);
  end
  assign probe_hit = |match;
endmodule

// File: rtl/lfp_load_align.sv
// General normal-path aligner: any size, any offset within the line.
module lfp_load_align
  import lfp_pkg::*;
(
  input  logic [WORD_BITS-1:0]  word,
  input  logic [LINE_OFF_W-1:0] off,
  input  logic [1:0]            size,
  input  logic                  sgn,
  output logic [WORD_BITS-1:0]  value,
  output logic                  crosses
);
  logic [WORD_BITS-1:0] shifted;
  logic [3:0]           nbytes;
  logic [3:0]           end_byte;
  lfp_size_e            sz;

  assign sz       = lfp_size_e'(size);
  assign shifted  = word >> {off, 3'b000};
  assign nbytes   = 4'd1 << size;
  assign end_byte = {1'b0, off} + nbytes;
  assign crosses  = end_byte > 4'd8;

  always_comb begin
    unique case (sz)
      SZ_BYTE:  value = {{56{sgn & shifted[7]}},  shifted[7:0]};
      SZ_HALF:  value = {{48{sgn & shifted[15]}}, shifted[15:0]};
      SZ_WORD:  value = {{32{sgn & shifted[31]}}, shifted[31:0]};
      default:  value = shifted;
    endcase
  end
endmodule

// File: rtl/lfp_fast_select.sv
// Narrow early-path selector: aligned 32/64-bit only.
module lfp_fast_select
  import lfp_pkg::*;
(
  input  logic [WORD_BITS-1:0]  word,
  input  logic [LINE_OFF_W-1:0] off,
  input  logic [1:0]            size,
  input  logic                  sgn,
  output logic                  eligible,
  output logic [WORD_BITS-1:0]  value
);
  logic [31:0] half_sel;
  lfp_size_e   sz;

  assign sz       = lfp_size_e'(size);
  assign half_sel = off[2] ? word[63:32] : word[31:0];

  always_comb begin
    eligible = 1'b0;
    value    = word;
    if (sz == SZ_DWORD) begin
      eligible = (off == 3'd0);
    end else if (sz == SZ_WORD) begin
      eligible = (off[1:0] == 2'd0);
      value    = sgn ? {{32{half_sel[31]}}, half_sel} : {32'd0, half_sel};
    end
  end
endmodule

// File: rtl/lfp_load_fastpath.sv
module lfp_load_fastpath
  import lfp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SETS     = 16,
  parameter int unsigned SB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic              req_mmio,
  input  logic              fill_we,
  input  logic              fill_inv,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [63:0]       fill_data,
  input  logic              st_push,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              st_drain,
  output logic              st_full,
  output logic              early_valid,
  output logic [63:0]       early_data,
  output logic              ex3_valid,
  output logic [63:0]       ex3_data,
  output logic              ex3_replay
);
  localparam int unsigned INDEX_W = $clog2(SETS);
  localparam int unsigned TAG_LO  = LINE_OFF_W + INDEX_W;
  localparam int unsigned TAG_W   = ADDR_W - TAG_LO;
  localparam int unsigned KEY_W   = ADDR_W - LINE_OFF_W;

  // EX2 stage registers
  logic              s2_valid;
  logic [ADDR_W-1:0] s2_addr;
  logic [1:0]        s2_size;
  logic              s2_signed;
  logic              s2_mmio;

  // Array read results (arrive in EX2)
  logic                 arr_valid;
  logic [TAG_W-1:0]     arr_tag;
  logic [WORD_BITS-1:0] arr_data;

  // EX2 combinational
  logic                 s2_hit, s2_hazard, fast_ok, s2_cross, early_go;
  logic [WORD_BITS-1:0] fast_value, norm_value;

  // Normal path stage toward EX3
  logic                 s3_valid, s3_replay;
  logic [WORD_BITS-1:0] s3_data;

  lfp_cache_arrays #(
    .INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(WORD_BITS)
  ) u_arrays (
    .clk      (clk),
    .rst      (rst),
    .rd_index (req_addr[TAG_LO-1:LINE_OFF_W]),
    .rd_valid (arr_valid),
    .rd_tag   (arr_tag),
    .rd_data  (arr_data),
    .wr_en    (fill_we),
    .wr_inv   (fill_inv),
    .wr_index (fill_addr[TAG_LO-1:LINE_OFF_W]),
    .wr_tag   (fill_addr[ADDR_W-1:TAG_LO]),
    .wr_data  (fill_data)
  );

  lfp_store_buf #(
    .DEPTH(SB_DEPTH), .KEY_W(KEY_W)
  ) u_stbuf (
    .clk       (clk),
    .rst       (rst),
    .push      (st_push),
    .push_key  (st_addr[ADDR_W-1:LINE_OFF_W]),
    .pop       (st_drain),
    .probe_key (s2_addr[ADDR_W-1:LINE_OFF_W]),
    .probe_hit (s2_hazard),
    .full      (st_full)
  );

  lfp_fast_select u_fast (
    .word     (arr_data),
    .off      (s2_addr[LINE_OFF_W-1:0]),
    .size     (s2_size),
    .sgn      (s2_signed),
    .eligible (fast_ok),
    .value    (fast_value)
  );

  lfp_load_align u_norm (
    .word    (arr_data),
    .off     (s2_addr[LINE_OFF_W-1:0]),
    .size    (s2_size),
    .sgn     (s2_signed),
    .value   (norm_value),
    .crosses (s2_cross)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
    end else begin
      s2_valid <= req_valid;
    end
    s2_addr   <= req_addr;
    s2_size   <= req_size;
    s2_signed <= req_signed;
    s2_mmio   <= req_mmio;
  end

  assign s2_hit   = arr_valid && (arr_tag == s2_addr[ADDR_W-1:TAG_LO]);
  assign early_go = s2_valid && s2_hit && !s2_mmio && !s2_hazard && fast_ok;

  // EX2 -> registered early result, and normal path into its EX3 pipe
  always_ff @(posedge clk) begin
    if (rst) begin
      early_valid <= 1'b0;
      s3_valid    <= 1'b0;
      s3_replay   <= 1'b0;
    end else begin
      early_valid <= early_go;
      s3_valid    <= s2_valid;
      s3_replay   <= s2_valid && (!s2_hit || s2_mmio || s2_hazard || s2_cross);
    end
    early_data <= fast_value;
    s3_data    <= norm_value;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ex3_valid  <= 1'b0;
      ex3_replay <= 1'b0;
    end else begin
      ex3_valid  <= s3_valid;
      ex3_replay <= s3_replay;
    end
    ex3_data <= s3_data;
  end
endmodule

// File: rtl/lfp_load_fastpath_chk.sv
module lfp_load_fastpath_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              req_mmio,
  input logic              st_push,
  input logic              st_drain,
  input logic              st_full,
  input logic              early_valid,
  input logic [63:0]       early_data,
  input logic              ex3_valid,
  input logic [63:0]       ex3_data,
  input logic              ex3_replay
);
  a_r7_early_matches_ex3: assert property (@(posedge clk) disable iff (rst)
    early_valid |=> (ex3_valid && !ex3_replay && ex3_data == $past(early_data)));

  a_r2_wide_only: assert property (@(posedge clk) disable iff (rst)
    early_valid |-> ($past(req_valid, 2) && $past(req_size, 2) >= 2'd2));

  a_r3_aligned_only: assert property (@(posedge clk) disable iff (rst)
    early_valid |-> (($past(req_addr[2:0], 2) == 3'd0) ||
                     ($past(req_size, 2) == 2'd2 && $past(req_addr[1:0], 2) == 2'd0)));

  a_r4_ram_only: assert property (@(posedge clk) disable iff (rst)
    early_valid |-> !$past(req_mmio, 2));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!early_valid && !ex3_valid && !st_full));

  a_r11_full_holds: assert property (@(posedge clk) disable iff (rst)
    (st_full && st_push && !st_drain) |=> st_full);
endmodule

bind lfp_load_fastpath lfp_load_fastpath_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .req_size    (req_size),
  .req_mmio    (req_mmio),
  .st_push     (st_push),
  .st_drain    (st_drain),
  .st_full     (st_full),
  .early_valid (early_valid),
  .early_data  (early_data),
  .ex3_valid   (ex3_valid),
  .ex3_data    (ex3_data),
  .ex3_replay  (ex3_replay)
);

// File: tb/lfp_load_fastpath_tb.sv
module lfp_load_fastpath_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_signed = 1'b0;
  logic        req_mmio = 1'b0;
  logic        fill_we = 1'b0;
  logic        fill_inv = 1'b0;
  logic [31:0] fill_addr = '0;
  logic [63:0] fill_data = '0;
  logic        st_push = 1'b0;
  logic [31:0] st_addr = '0;
  logic        st_drain = 1'b0;
  logic        st_full;
  logic        early_valid;
  logic [63:0] early_data;
  logic        ex3_valid;
  logic [63:0] ex3_data;
  logic        ex3_replay;

  int checks = 0;
  int fails  = 0;
  logic [63:0] mem [64];

  always #2 clk = ~clk;

  lfp_load_fastpath u_dut (.*);

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_load(input logic [63:0] w, input int off,
                                           input int sz, input bit sgn);
    int n = 1 << sz;
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r[8*i +: 8] = w[8*(off+i) +: 8];
    if (sgn) for (int b = 8*n; b < 64; b++) r[b] = r[8*n-1];
    return r;
  endfunction

  task automatic fill_line(input logic [31:0] a, input logic [63:0] d);
    @(negedge clk);
    fill_we = 1'b1; fill_addr = a; fill_data = d;
    mem[a[8:3]] = d;
    @(negedge clk);
    fill_we = 1'b0;
  endtask

  task automatic push_st(input logic [31:0] a);
    @(negedge clk); st_push = 1'b1; st_addr = a;
    @(negedge clk); st_push = 1'b0;
  endtask

  task automatic drain_st();
    @(negedge clk); st_drain = 1'b1;
    @(negedge clk); st_drain = 1'b0;
  endtask

  // Request edge E0; early sampled after E1; EX3 sampled after E2.
  task automatic do_load(input logic [31:0] a, input logic [1:0] sz, input bit sgn,
                         input bit mmio, input bit exp_early, input bit exp_replay,
                         input string rq);
    logic [63:0] exp_d;
    exp_d = ref_load(mem[a[8:3]], int'(a[2:0]), int'(sz), sgn);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_signed = sgn; req_mmio = mmio;
    @(negedge clk);
    req_valid = 1'b0; req_mmio = 1'b0;
    @(negedge clk);
    chk(early_valid == exp_early, rq, "early_valid", 64'(early_valid), 64'(exp_early));
    if (exp_early) chk(early_data == exp_d, rq, "early_data", early_data, exp_d);
    @(negedge clk);
    chk(ex3_valid == 1'b1, rq, "ex3_valid", 64'(ex3_valid), 64'd1);
    chk(ex3_replay == exp_replay, rq, "ex3_replay", 64'(ex3_replay), 64'(exp_replay));
    if (!exp_replay) chk(ex3_data == exp_d, rq, "ex3_data", ex3_data, exp_d);
  endtask

  task automatic t_reset();
    chk(!early_valid, "R10", "early_valid", 64'(early_valid), 64'd0);
    chk(!ex3_valid,   "R10", "ex3_valid",   64'(ex3_valid),   64'd0);
    chk(!st_full,     "R10", "st_full",     64'(st_full),     64'd0);
  endtask

  task automatic t_fast_wide();
    fill_line(32'h0000_1008, 64'h1122_3344_5566_7788);
    do_load(32'h0000_1008, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, "R1/R7 dword");
    do_load(32'h0000_100C, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, "R1/R7 word hi");
  endtask

  task automatic t_extend();
    fill_line(32'h0000_1010, 64'h7000_0001_8000_0002);
    do_load(32'h0000_1010, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, "R8 signed neg");
    do_load(32'h0000_1010, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, "R8 unsigned");
    do_load(32'h0000_1014, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, "R8 signed pos");
  endtask

  task automatic t_narrow();
    do_load(32'h0000_1010, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R2 byte");
    do_load(32'h0000_1012, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 half");
  endtask

  task automatic t_misalign();
    do_load(32'h0000_100A, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R3/R9 word off2");
    do_load(32'h0000_1009, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 half off1");
    do_load(32'h0000_100C, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, "R9 dword cross");
  endtask

  task automatic t_mmio();
    do_load(32'h0000_1008, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, "R4 mmio");
  endtask

  task automatic t_miss();
    do_load(32'h0000_1038, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, "R6 invalid line");
    do_load(32'h0000_2008, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, "R6 tag mismatch");
  endtask

  task automatic t_hazard();
    push_st(32'h0000_100C);
    do_load(32'h0000_1008, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, "R5 same line");
    do_load(32'h0000_1010, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, "R5 other line");
    drain_st();
    do_load(32'h0000_1008, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, "R5 after drain");
  endtask

  task automatic t_full();
    fill_line(32'h0000_1020, 64'hCAFE_F00D_DEAD_BEEF);
    push_st(32'h0000_3000);
    push_st(32'h0000_3008);
    push_st(32'h0000_3010);
    push_st(32'h0000_3018);
    chk(st_full, "R11", "st_full", 64'(st_full), 64'd1);
    push_st(32'h0000_1020);
    do_load(32'h0000_1020, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, "R11 ignored push");
    for (int i = 0; i < 4; i++) drain_st();
    chk(!st_full, "R11", "st_full drained", 64'(st_full), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 64'h8123_4567_89AB_CDEF ^ (64'(i) * 64'h0101_0101_0101_0101);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fast_wide();
    t_extend();
    t_narrow();
    t_misalign();
    t_mmio();
    t_miss();
    t_hazard();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule